// File: doc/BRIEF.md
# UART Receive Byte Queue with Trigger Thresholds

This block sits between the serial deserializer of a 16550-compatible UART and the host register interface. Each time the deserializer strobes `rx_valid`, the block stores the byte. The host takes bytes out by pulsing `host_rd` while it samples `host_rdata`, which always shows the oldest stored byte. When the queue is switched off, the block keeps a single holding byte instead.

The host programs the block through writes to the FIFO control byte, `cfg_wdata`. Bit 0 turns queue mode on. Bit 1 flushes the received bytes. Bits 7:6 choose how many stored bytes are needed before the block reports data. If fewer bytes than that are waiting, a timer counts character-time ticks on `char_tick`, and after sixteen of them the block reports the data anyway. When bytes arrive that cannot be stored, the block flags an overrun and pulses a line-status event for the interrupt logic that lies outside this block.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the block is in single-byte mode with trigger select 00. `fill_level`, `data_ready`, `overrun`, `rxd_evt`, `tmo_evt` and `lsr_evt` are 0, and `host_rdata` is 0x00.
- R2: In queue mode the block holds up to 16 bytes. Reads return them in arrival order, each read lowers `fill_level` by one, and `host_rdata` shows the oldest byte before the read strobe.
- R3: `cfg_wdata[7:6]` selects the trigger threshold: 00 selects 1 byte, 01 selects 4, 10 selects 8 and 11 selects 14.
- R4: When an enqueue brings `fill_level` to the threshold or above, `data_ready` and `rxd_evt` are set on the next cycle, and any running timeout is cancelled.
- R5: An enqueue that leaves `fill_level` below the threshold restarts the timeout. After 16 `char_tick` pulses with no further enqueue, `data_ready` and `tmo_evt` are set.
- R6: A byte that arrives while 16 bytes are stored is dropped. It sets the sticky `overrun` flag and raises `lsr_evt` for exactly one cycle, and `fill_level` stays at 16.
- R7: A control write with bit 0 different from the current mode, or with bit 1 set, empties the queue and clears `data_ready`, `rxd_evt` and `tmo_evt`. Bit 2 has no effect on the received bytes.
- R8: A read that takes the last stored byte clears `data_ready`, `rxd_evt` and `tmo_evt`.
- R9: A read while the queue is empty leaves `fill_level` at 0, and `host_rdata` keeps the last byte that was read out.
- R10: In single-byte mode a received byte sets `data_ready` and `rxd_evt`. If `data_ready` was already set, `overrun` is set, `lsr_evt` pulses, and the new byte replaces the held one. A read clears `data_ready`.
- R11: `ovr_clr` clears `overrun`. If an overrun occurs in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Strobe from the deserializer: a received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| cfg_we | input | 1 | Write strobe for the FIFO control byte |
| cfg_wdata | input | 8 | FIFO control byte (bit 0 mode, bit 1 flush, bits 7:6 trigger) |
| host_rd | input | 1 | Host read of the receive buffer; pops one byte; ignored in a cycle with `cfg_we` |
| host_rdata | output | 8 | Oldest stored byte, or the holding byte in single-byte mode |
| ovr_clr | input | 1 | Clears the overrun flag, pulsed by a line-status read |
| char_tick | input | 1 | One pulse per character time |
| data_ready | output | 1 | Received data is reported to the host |
| overrun | output | 1 | Sticky flag: a byte was lost |
| rxd_evt | output | 1 | Received-data event, held until the queue drains |
| tmo_evt | output | 1 | Character-timeout event, held until the queue drains |
| lsr_evt | output | 1 | One-cycle line-status event on an overrun |
| fill_level | output | 5 | Number of stored bytes |

## Verification
A pointer or count that slips shows up at the ports within one read: a byte comes back out of order, or `fill_level` disagrees with the number of bytes pushed minus the number read. A wrong threshold decode or a wrong timer count shows up as `data_ready` rising one enqueue or one tick too early or too late, so each threshold and the 15th and 16th tick are sampled exactly. Flush and overrun bugs show up on the first read after the event, as stale bytes or a missing `overrun` flag.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        TRIG_1  = 2'd0,
        TRIG_4  = 2'd1,
        TRIG_8  = 2'd2,
        TRIG_14 = 2'd3
    } trig_sel_e;

    localparam int CFG_W        = 8;
    localparam int CFG_MODE_BIT = 0;
    localparam int CFG_FLUSH    = 1;
    localparam int CFG_TRIG_LSB = 6;

    function automatic int trig_count(trig_sel_e s);
        case (s)
            TRIG_1:  return 1;
            TRIG_4:  return 4;
            TRIG_8:  return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_cfg_decode.sv
module rxq_cfg_decode
    import rxq_pkg::*;
(
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             mode_q,
    input  trig_sel_e        trig_q,
    output logic             mode_d,
    output trig_sel_e        trig_d,
    output logic             flush
);
    logic unused_cfg_bits;

    always_comb begin
        mode_d = mode_q;
        trig_d = trig_q;
        flush  = 1'b0;
        if (we) begin
            mode_d = wdata[CFG_MODE_BIT];
            trig_d = trig_sel_e'(wdata[CFG_TRIG_LSB +: 2]);
            flush  = (wdata[CFG_MODE_BIT] != mode_q) || wdata[CFG_FLUSH];
        end
    end

    // bits 2..5 do not concern the receive side
    assign unused_cfg_bits = ^wdata[5:2];

endmodule

// File: rtl/rxq_char_timer.sv
module rxq_char_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic tick,
    output logic expire
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign expire = tmr_q.run && tick && (tmr_q.cnt == CNT_W'(LIMIT - 1));

    always_comb begin
        tmr_d = tmr_q;
        if (stop) begin
            tmr_d.run = 1'b0;
            tmr_d.cnt = '0;
        end else if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
        end else if (expire) begin
            tmr_d.run = 1'b0;
            tmr_d.cnt = '0;
        end else if (tmr_q.run && tick) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           push,
    input  logic                           pop,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              head,
    output logic [$clog2(DEPTH+1)-1:0]     level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [LVL_W-1:0]             cnt;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head  = st_q.mem[st_q.rd];
    assign level = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.cnt = '0;
        end
        if (pop && st_d.cnt != '0) begin
            st_d.rd  = nxt(st_d.rd);
            st_d.cnt = st_d.cnt - 1'b1;
        end
        if (push && st_d.cnt != LVL_W'(DEPTH)) begin
            st_d.mem[st_d.wr] = wdata;
            st_d.wr           = nxt(st_d.wr);
            st_d.cnt          = st_d.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DATA_W    = 8,
    parameter int TMO_CHARS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_valid,
    input  logic [DATA_W-1:0]          rx_byte,
    input  logic                       cfg_we,
    input  logic [CFG_W-1:0]           cfg_wdata,
    input  logic                       host_rd,
    output logic [DATA_W-1:0]          host_rdata,
    input  logic                       ovr_clr,
    input  logic                       char_tick,
    output logic                       data_ready,
    output logic                       overrun,
    output logic                       rxd_evt,
    output logic                       tmo_evt,
    output logic                       lsr_evt,
    output logic [$clog2(DEPTH+1)-1:0] fill_level
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              mode;
        trig_sel_e         trig;
        logic              data_ready;
        logic              overrun;
        logic              rxd_evt;
        logic              tmo_evt;
        logic              lsr_evt;
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] last;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              dec_mode;
    trig_sel_e         dec_trig;
    logic              dec_flush;
    logic              st_push, st_pop;
    logic [DATA_W-1:0] st_head;
    logic [LVL_W-1:0]  st_level;
    logic [LVL_W-1:0]  lvl_w;
    logic              t_start, t_stop, t_expire;
    logic              rd_eff;
    logic              fifo_on;

    rxq_cfg_decode u_dec (
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .mode_q (ctl_q.mode),
        .trig_q (ctl_q.trig),
        .mode_d (dec_mode),
        .trig_d (dec_trig),
        .flush  (dec_flush)
    );

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (dec_flush),
        .push  (st_push),
        .pop   (st_pop),
        .wdata (rx_byte),
        .head  (st_head),
        .level (st_level)
    );

    rxq_char_timer #(.LIMIT(TMO_CHARS)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (t_start),
        .stop   (t_stop),
        .tick   (char_tick),
        .expire (t_expire)
    );

    assign rd_eff = host_rd && !cfg_we;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.lsr_evt = 1'b0;
        ctl_d.mode    = dec_mode;
        ctl_d.trig    = dec_trig;
        st_push       = 1'b0;
        st_pop        = 1'b0;
        t_start       = 1'b0;
        t_stop        = dec_flush;
        lvl_w         = dec_flush ? '0 : st_level;

        if (ovr_clr) ctl_d.overrun = 1'b0;

        if (dec_flush) begin
            ctl_d.data_ready = 1'b0;
            ctl_d.rxd_evt    = 1'b0;
            ctl_d.tmo_evt    = 1'b0;
        end

        if (ctl_d.mode) begin
            // queue mode: timeout, then read, then enqueue
            if (t_expire && !dec_flush) begin
                ctl_d.data_ready = 1'b1;
                ctl_d.tmo_evt    = 1'b1;
            end
            if (rd_eff && lvl_w != '0) begin
                st_pop     = 1'b1;
                ctl_d.last = st_head;
                lvl_w      = lvl_w - 1'b1;
                if (lvl_w == '0) begin
                    ctl_d.data_ready = 1'b0;
                    ctl_d.rxd_evt    = 1'b0;
                    ctl_d.tmo_evt    = 1'b0;
                    t_stop           = 1'b1;
                end
            end
            if (rx_valid) begin
                if (lvl_w == LVL_W'(DEPTH)) begin
                    ctl_d.overrun = 1'b1;
                    ctl_d.lsr_evt = 1'b1;
                end else begin
                    st_push = 1'b1;
                    lvl_w   = lvl_w + 1'b1;
                    if (lvl_w >= LVL_W'(trig_count(ctl_d.trig))) begin
                        ctl_d.data_ready = 1'b1;
                        ctl_d.rxd_evt    = 1'b1;
                        t_stop           = 1'b1;
                    end else begin
                        t_start = 1'b1;
                        t_stop  = 1'b0;
                    end
                end
            end
        end else begin
            // single holding byte
            if (rd_eff) begin
                ctl_d.data_ready = 1'b0;
                ctl_d.rxd_evt    = 1'b0;
            end
            if (rx_valid) begin
                if (ctl_d.data_ready) begin
                    ctl_d.overrun = 1'b1;
                    ctl_d.lsr_evt = 1'b1;
                end
                ctl_d.hold       = rx_byte;
                ctl_d.data_ready = 1'b1;
                ctl_d.rxd_evt    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign fifo_on    = ctl_q.mode;
    assign host_rdata = ctl_q.mode ? ((st_level != '0) ? st_head : ctl_q.last)
                                   : ctl_q.hold;
    assign data_ready = ctl_q.data_ready;
    assign overrun    = ctl_q.overrun;
    assign rxd_evt    = ctl_q.rxd_evt;
    assign tmo_evt    = ctl_q.tmo_evt;
    assign lsr_evt    = ctl_q.lsr_evt;
    assign fill_level = st_level;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       fifo_on,
    input logic                       rx_valid,
    input logic [DATA_W-1:0]          rx_byte,
    input logic                       cfg_we,
    input logic                       host_rd,
    input logic [DATA_W-1:0]          host_rdata,
    input logic                       data_ready,
    input logic                       overrun,
    input logic                       rxd_evt,
    input logic                       tmo_evt,
    input logic                       lsr_evt,
    input logic [$clog2(DEPTH+1)-1:0] fill_level
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= LVL_W'(DEPTH));

    a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on && rx_valid && fill_level == LVL_W'(DEPTH) && !host_rd && !cfg_we
        |=> overrun && lsr_evt && fill_level == LVL_W'(DEPTH));

    a_r8_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on && host_rd && fill_level == LVL_W'(1) && !rx_valid && !cfg_we
        |=> !data_ready && !rxd_evt && !tmo_evt && fill_level == '0);

    a_r9_empty_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on && host_rd && fill_level == '0 && !rx_valid && !cfg_we
        |=> fill_level == '0 && host_rdata == $past(host_rdata));

    a_r5_timeout_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_evt) |-> data_ready);

    a_r10_hold_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_on && rx_valid && data_ready && !host_rd && !cfg_we
        |=> overrun && lsr_evt && host_rdata == $past(rx_byte));

endmodule

bind uart_rx_fifo rxq_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_on    (fifo_on),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .cfg_we     (cfg_we),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .data_ready (data_ready),
    .overrun    (overrun),
    .rxd_evt    (rxd_evt),
    .tmo_evt    (tmo_evt),
    .lsr_evt    (lsr_evt),
    .fill_level (fill_level)
);

// File: tb/tb_uart_rx_fifo.sv
module tb_uart_rx_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       ovr_clr = 1'b0;
    logic       char_tick = 1'b0;
    logic       data_ready, overrun, rxd_evt, tmo_evt, lsr_evt;
    logic [4:0] fill_level;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    uart_rx_fifo dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .ovr_clr(ovr_clr), .char_tick(char_tick),
        .data_ready(data_ready), .overrun(overrun), .rxd_evt(rxd_evt),
        .tmo_evt(tmo_evt), .lsr_evt(lsr_evt), .fill_level(fill_level)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic push(logic [7:0] d);
        rx_valid = 1'b1; rx_byte = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic cfg(logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pop(output logic [7:0] v);
        host_rd = 1'b1;
        v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1'b1;
            @(negedge clk);
        end
        char_tick = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 level", fill_level, 0);
        check("R1 data_ready", data_ready, 0);
        check("R1 overrun", overrun, 0);
        check("R1 events", {rxd_evt, tmo_evt, lsr_evt}, 0);
        check("R1 rdata", host_rdata, 8'h00);
    endtask

    task automatic t_order();
        logic [7:0] v;
        cfg(8'h01);                       // queue mode, threshold 1
        push(8'hA1);
        check("R3 trig1 ready", data_ready, 1);
        check("R3 trig1 evt", rxd_evt, 1);
        push(8'hB2); push(8'hC3);
        check("R2 level 3", fill_level, 3);
        pop(v); check("R2 first", v, 8'hA1);
        pop(v); check("R2 second", v, 8'hB2);
        check("R2 level 1", fill_level, 1);
        pop(v); check("R2 third", v, 8'hC3);
        check("R8 ready cleared", data_ready, 0);
        check("R8 evt cleared", rxd_evt, 0);
        pop(v); check("R9 empty read value", v, 8'hC3);
        check("R9 level stays 0", fill_level, 0);
        check("R9 rdata kept", host_rdata, 8'hC3);
    endtask

    task automatic t_trig4();
        logic [7:0] v;
        cfg(8'h43);                       // threshold 4, flush
        push(8'h10); push(8'h11); push(8'h12);
        check("R3 trig4 below", data_ready, 0);
        push(8'h13);
        check("R4 trig4 ready", data_ready, 1);
        check("R4 trig4 evt", rxd_evt, 1);
        ticks(20);
        check("R4 timeout cancelled", tmo_evt, 0);
        for (int i = 0; i < 4; i++) pop(v);
        check("R8 drained", data_ready, 0);
    endtask

    task automatic t_trig14();
        cfg(8'hC3);
        for (int i = 0; i < 13; i++) push(8'(i));
        check("R3 trig14 at 13", data_ready, 0);
        push(8'h0D);
        check("R3 trig14 at 14", data_ready, 1);
        cfg(8'h83);                       // threshold 8, flush
        check("R7 flush level", fill_level, 0);
        check("R7 flush ready", data_ready, 0);
    endtask

    task automatic t_timeout();
        logic [7:0] v;
        push(8'h21);
        ticks(10);
        push(8'h22);                      // restarts timer
        ticks(15);
        check("R5 no expiry at 15", tmo_evt, 0);
        check("R5 not ready at 15", data_ready, 0);
        ticks(1);
        check("R5 expiry at 16", tmo_evt, 1);
        check("R5 ready at 16", data_ready, 1);
        pop(v); check("R5 data", v, 8'h21);
        pop(v);
        check("R8 tmo cleared", tmo_evt, 0);
        check("R8 ready cleared", data_ready, 0);
    endtask

    task automatic t_full();
        logic [7:0] v;
        cfg(8'h03);                       // threshold 1, flush
        for (int i = 0; i < 16; i++) push(8'h40 + 8'(i));
        check("R2 level 16", fill_level, 16);
        check("R6 no lsr yet", lsr_evt, 0);
        push(8'hEE);
        check("R6 lsr pulse", lsr_evt, 1);
        check("R6 overrun", overrun, 1);
        check("R6 level stays", fill_level, 16);
        @(negedge clk);
        check("R6 lsr one cycle", lsr_evt, 0);
        for (int i = 0; i < 16; i++) begin
            pop(v);
            check("R6 kept bytes", v, 8'h40 + i);
        end
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        check("R11 overrun cleared", overrun, 0);
    endtask

    task automatic t_cfg_bits();
        push(8'h31); push(8'h32); push(8'h33);
        cfg(8'h05);                       // bit 2 only, mode unchanged
        check("R7 bit2 level", fill_level, 3);
        check("R7 bit2 ready", data_ready, 1);
        cfg(8'h03);
        check("R7 bit1 level", fill_level, 0);
        check("R7 bit1 ready", data_ready, 0);
    endtask

    task automatic t_single();
        logic [7:0] v;
        cfg(8'h00);                       // single-byte mode
        push(8'h11);
        check("R10 ready", data_ready, 1);
        check("R10 no overrun", overrun, 0);
        check("R10 value", host_rdata, 8'h11);
        push(8'h22);
        check("R10 overrun", overrun, 1);
        check("R10 lsr", lsr_evt, 1);
        check("R10 replaced", host_rdata, 8'h22);
        pop(v); check("R10 read value", v, 8'h22);
        check("R10 read clears", data_ready, 0);
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        push(8'h44);
        check("R11 clear held", overrun, 0);
        ovr_clr = 1'b1; push(8'h55); ovr_clr = 1'b0;
        check("R11 set wins", overrun, 1);
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        check("R11 cleared", overrun, 0);
        cfg(8'h01);                       // mode 0 -> 1 empties
        check("R7 mode change ready", data_ready, 0);
        check("R7 mode change level", fill_level, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_trig4();
        t_trig14();
        t_timeout();
        t_full();
        t_cfg_bits();
        t_single();
        finish_run();
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule